// File: doc/BRIEF.md
# Trap Request Arbiter

This block decides, once per clock, which pending event becomes the processor's next trap. It looks at three kinds of request: a vector of synchronous exception requests, one software trap request that carries a 7-bit trap number, and a 4-bit external interrupt request level. It compares the interrupt level with the processor's programmable interrupt mask level and with the trap-enable bit. The winning event is registered. For one cycle the block raises a take strobe together with the 8-bit trap type of the event that won.

Nothing is latched inside the block. Every source must hold its request until it sees its trap taken, and a request that goes away before it wins is lost. When the winner is an interrupt, an acknowledge pulse goes back to the interrupt source in the same cycle as the take strobe. Exception requests that lose stay visible at the inputs, so they compete again in the following cycles.

Top module: `trap_arbiter`

## Requirements
- R1: While reset is low, and on the first sampling edge after it, `take_o`, `irq_ack_o` and `trap_type_o` are all 0.
- R2: With traps enabled and no exception or software request, an interrupt level n in 1..14 is taken only when n is strictly greater than `mask_level_i`. It is reported with trap type 16+n (0x11..0x1E) and `irq_ack_o` high.
- R3: Level 15 is taken whatever `mask_level_i` holds, including 15, and is reported as trap type 0x1F with `irq_ack_o` high.
- R4: Level 0 means no request and is never taken. Level 1 with a mask of 0 is taken as trap type 0x11.
- R5: When `traps_en_i` is 0, no interrupt is ever taken, and this includes level 15.
- R6: Any exception request beats the software request and any interrupt. Exception index i is reported as trap type `EXC_TT_BASE`+i (default 0x01+i), with `irq_ack_o` low. Exceptions are reported whatever the value of `traps_en_i`.
- R7: When several exception bits are set together, the lowest index wins.
- R8: A software trap request with number k is reported as trap type 0x80|k, with `irq_ack_o` low. It loses to any exception and beats any interrupt, and it is reported whatever the value of `traps_en_i`.
- R9: The decision is registered. Inputs sampled at one rising edge show on the outputs after that edge for exactly that cycle. With no request accepted, `take_o` is 0 and `trap_type_o` is 0x00. A request that is removed is not remembered.
- R10: `irq_ack_o` is high only in a cycle in which `take_o` is high and an interrupt was the winner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_level_i | input | 4 | External interrupt request level; 0 means none |
| mask_level_i | input | 4 | Processor interrupt mask level |
| traps_en_i | input | 1 | Trap enable; 0 blocks interrupts |
| exc_req_i | input | NEXC | Exception requests; bit 0 has highest priority |
| sw_trap_i | input | 1 | Software trap request |
| sw_trap_num_i | input | 7 | Software trap number |
| take_o | output | 1 | One-cycle strobe: a trap is taken |
| trap_type_o | output | 8 | Trap type of the taken event; 0 when idle |
| irq_ack_o | output | 1 | Acknowledge to the interrupt source |

## Verification
The bench probes the mask comparison at its edge: level equal to the mask, level just above it, level 1 against a mask of 0, and level 15 against a mask of 15. A design that used greater-or-equal, or that masked level 15, would take a trap where none is due or miss one that is due. It also sets several exception bits together and mixes exceptions with software and interrupt requests. A wrong priority chain would report the wrong trap type or raise a stray acknowledge. Finally, it pulses a request for one cycle and clears traps-enable. A design that latched requests, or that ignored the enable, would produce a take strobe after the request had gone.

// File: rtl/trap_arb_pkg.sv
package trap_arb_pkg;
  localparam int TT_W        = 8;
  localparam int LVL_W       = 4;
  localparam int SWN_W       = 7;
  localparam logic [LVL_W-1:0] NMI_LEVEL = 4'hF;

  // An interrupt level passes when enabled, non-zero and above the mask,
  // or when it is the non-maskable level.
  function automatic logic irq_passes(input logic [LVL_W-1:0] lvl,
                                      input logic [LVL_W-1:0] mask,
                                      input logic en);
    return en && (lvl != '0) && ((lvl == NMI_LEVEL) || (lvl > mask));
  endfunction

  // Interrupt trap types sit at 16 + level.
  function automatic logic [TT_W-1:0] irq_type(input logic [LVL_W-1:0] lvl);
    return 8'h10 | {4'h0, lvl};
  endfunction

  // Software trap types occupy the upper half of the space.
  function automatic logic [TT_W-1:0] sw_type(input logic [SWN_W-1:0] num);
    return {1'b1, num};
  endfunction

  function automatic logic [TT_W-1:0] exc_type(input logic [TT_W-1:0] base,
                                               input int unsigned idx);
    return base + TT_W'(idx);
  endfunction
endpackage

// File: rtl/exc_picker.sv
module exc_picker #(
  parameter int N     = 8,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic [N-1:0]     grant_o,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  // seen[i] is high when some lower index is already requesting
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign seen[i+1]  = seen[i] | req_i[i];
    assign grant_o[i] = req_i[i] & ~seen[i];
  end

  assign any_o = seen[N];

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (grant_o[i]) idx_o = idx_o | IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_filter.sv
module irq_filter
  import trap_arb_pkg::*;
(
  input  logic [LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0] mask_i,
  input  logic             en_i,
  output logic             pass_o,
  output logic [TT_W-1:0]  tt_o
);
  assign pass_o = irq_passes(level_i, mask_i, en_i);
  assign tt_o   = irq_type(level_i);
endmodule

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_arb_pkg::*;
#(
  parameter int         NEXC        = 8,
  parameter logic [7:0] EXC_TT_BASE = 8'h01
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      irq_level_i,
  input  logic [3:0]      mask_level_i,
  input  logic            traps_en_i,
  input  logic [NEXC-1:0] exc_req_i,
  input  logic            sw_trap_i,
  input  logic [6:0]      sw_trap_num_i,
  output logic            take_o,
  output logic [7:0]      trap_type_o,
  output logic            irq_ack_o
);
  localparam int IDX_W = (NEXC > 1) ? $clog2(NEXC) : 1;

  // Named internal events
  logic [NEXC-1:0]  exc_grant;
  logic             exc_any;
  logic [IDX_W-1:0] exc_idx;
  logic             irq_pass;
  logic [TT_W-1:0]  irq_tt;
  logic             win_exc, win_sw, win_irq, win_any;
  logic [TT_W-1:0]  next_tt;

  exc_picker #(.N(NEXC), .IDX_W(IDX_W)) u_pick (
    .req_i  (exc_req_i),
    .grant_o(exc_grant),
    .any_o  (exc_any),
    .idx_o  (exc_idx)
  );

  irq_filter u_irq (
    .level_i(irq_level_i),
    .mask_i (mask_level_i),
    .en_i   (traps_en_i),
    .pass_o (irq_pass),
    .tt_o   (irq_tt)
  );

  // Fixed ranking: exceptions, then software trap, then interrupt
  assign win_exc = exc_any;
  assign win_sw  = !exc_any && sw_trap_i;
  assign win_irq = !exc_any && !sw_trap_i && irq_pass;
  assign win_any = win_exc || win_sw || win_irq;

  always_comb begin
    next_tt = '0;
    if (win_exc)      next_tt = exc_type(EXC_TT_BASE, 32'(exc_idx));
    else if (win_sw)  next_tt = sw_type(sw_trap_num_i);
    else if (win_irq) next_tt = irq_tt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take_o      <= 1'b0;
      trap_type_o <= '0;
      irq_ack_o   <= 1'b0;
    end else begin
      take_o      <= win_any;
      trap_type_o <= next_tt;
      irq_ack_o   <= win_irq;
    end
  end

  // ---------------- assertions ----------------
  p_single_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(exc_grant));

  p_ack_with_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack_o |-> take_o);

  p_idle_type_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |-> (trap_type_o == 8'h00));

  p_masked_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req_i == '0 && !sw_trap_i && irq_level_i != 4'hF &&
     irq_level_i <= mask_level_i) |=> !take_o);

  p_traps_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!traps_en_i && exc_req_i == '0 && !sw_trap_i) |=> !take_o);

  p_nmi_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (traps_en_i && exc_req_i == '0 && !sw_trap_i && irq_level_i == 4'hF)
    |=> (take_o && irq_ack_o && trap_type_o == 8'h1F));

  p_exc_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req_i != '0) |=> (take_o && !irq_ack_o &&
     trap_type_o >= EXC_TT_BASE && trap_type_o < EXC_TT_BASE + 8'(NEXC)));

  p_sw_type_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req_i == '0 && sw_trap_i) |=> (take_o && !irq_ack_o &&
     trap_type_o[7]));
endmodule

// File: tb/trap_arbiter_test.sv
module trap_arbiter_test;
  localparam int CLK_PERIOD = 10;
  localparam int NEXC = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] irl = '0, pil = '0;
  logic       et = 1'b0;
  logic [7:0] exc = '0;
  logic       sw = 1'b0;
  logic [6:0] swn = '0;
  logic       take, ack;
  logic [7:0] tt;

  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_arbiter #(.NEXC(NEXC), .EXC_TT_BASE(8'h01)) uut (
    .clk(clk), .rst_n(rst_n), .irq_level_i(irl), .mask_level_i(pil),
    .traps_en_i(et), .exc_req_i(exc), .sw_trap_i(sw), .sw_trap_num_i(swn),
    .take_o(take), .trap_type_o(tt), .irq_ack_o(ack)
  );

  typedef struct packed {
    logic [3:0] irl;
    logic [3:0] pil;
    logic       et;
    logic [7:0] exc;
    logic       sw;
    logic [6:0] swn;
    logic       e_take;
    logic [7:0] e_tt;
    logic       e_ack;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{4'd5,  4'd4,  1'b1, 8'h00, 1'b0, 7'h00, 1'b1, 8'h15, 1'b1, 4'd2},  // R2 above mask
    '{4'd4,  4'd4,  1'b1, 8'h00, 1'b0, 7'h00, 1'b0, 8'h00, 1'b0, 4'd2},  // R2 equal
    '{4'd3,  4'd7,  1'b1, 8'h00, 1'b0, 7'h00, 1'b0, 8'h00, 1'b0, 4'd2},  // R2 below
    '{4'd15, 4'd15, 1'b1, 8'h00, 1'b0, 7'h00, 1'b1, 8'h1F, 1'b1, 4'd3},  // R3
    '{4'd15, 4'd0,  1'b1, 8'h00, 1'b0, 7'h00, 1'b1, 8'h1F, 1'b1, 4'd3},  // R3
    '{4'd0,  4'd0,  1'b1, 8'h00, 1'b0, 7'h00, 1'b0, 8'h00, 1'b0, 4'd4},  // R4 no request
    '{4'd1,  4'd0,  1'b1, 8'h00, 1'b0, 7'h00, 1'b1, 8'h11, 1'b1, 4'd4},  // R4 lowest level
    '{4'd9,  4'd0,  1'b0, 8'h00, 1'b0, 7'h00, 1'b0, 8'h00, 1'b0, 4'd5},  // R5
    '{4'd15, 4'd0,  1'b0, 8'h00, 1'b0, 7'h00, 1'b0, 8'h00, 1'b0, 4'd5},  // R5 nmi blocked
    '{4'd15, 4'd0,  1'b1, 8'h20, 1'b0, 7'h00, 1'b1, 8'h06, 1'b0, 4'd6},  // R6 beats irq
    '{4'd0,  4'd0,  1'b0, 8'h10, 1'b0, 7'h00, 1'b1, 8'h05, 1'b0, 4'd6},  // R6 with ET=0
    '{4'd0,  4'd0,  1'b1, 8'hA4, 1'b0, 7'h00, 1'b1, 8'h03, 1'b0, 4'd7},  // R7
    '{4'd0,  4'd0,  1'b1, 8'h80, 1'b0, 7'h00, 1'b1, 8'h08, 1'b0, 4'd7},  // R7 top index
    '{4'd12, 4'd0,  1'b1, 8'h00, 1'b1, 7'h05, 1'b1, 8'h85, 1'b0, 4'd8},  // R8 beats irq
    '{4'd0,  4'd0,  1'b1, 8'h01, 1'b1, 7'h7F, 1'b1, 8'h01, 1'b0, 4'd8},  // R8 loses to exc
    '{4'd0,  4'd0,  1'b1, 8'h00, 1'b1, 7'h7F, 1'b1, 8'hFF, 1'b0, 4'd8},  // R8
    '{4'd0,  4'd0,  1'b0, 8'h00, 1'b1, 7'h03, 1'b1, 8'h83, 1'b0, 4'd8},  // R8 with ET=0
    '{4'd0,  4'd9,  1'b1, 8'h00, 1'b0, 7'h00, 1'b0, 8'h00, 1'b0, 4'd9}   // R9 idle
  };

  task automatic check(input logic e_take, input logic [7:0] e_tt,
                       input logic e_ack, input int rq, input string what);
    checks++;
    if (take !== e_take || tt !== e_tt || ack !== e_ack) begin
      errors++;
      $display("FAIL R%0d %s: take=%b tt=%h ack=%b expected take=%b tt=%h ack=%b",
               rq, what, take, tt, ack, e_take, e_tt, e_ack);
    end
  endtask

  task automatic idle_inputs();
    irl = '0; pil = '0; et = 1'b1; exc = '0; sw = 1'b0; swn = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state, with a live request present
    et = 1'b1; irl = 4'd15;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(1'b0, 8'h00, 1'b0, 1, "during reset");
    idle_inputs();
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check(1'b0, 8'h00, 1'b0, 1, "first edge after reset");

    // Vector table
    for (int i = 0; i < NV; i++) begin
      irl = VECS[i].irl; pil = VECS[i].pil; et = VECS[i].et;
      exc = VECS[i].exc; sw = VECS[i].sw; swn = VECS[i].swn;
      @(posedge clk); @(negedge clk);
      check(VECS[i].e_take, VECS[i].e_tt, VECS[i].e_ack, int'(VECS[i].req),
            $sformatf("vector %0d", i));
    end

    // R9: one-cycle request is taken once, then forgotten
    idle_inputs();
    irl = 4'd7; pil = 4'd2;
    @(posedge clk); @(negedge clk);
    check(1'b1, 8'h17, 1'b1, 9, "pulse taken");
    irl = 4'd0;
    @(posedge clk); @(negedge clk);
    check(1'b0, 8'h00, 1'b0, 9, "pulse not latched");

    // R10: exception and interrupt together, no acknowledge
    irl = 4'd14; pil = 4'd0; exc = 8'h02;
    @(posedge clk); @(negedge clk);
    check(1'b1, 8'h02, 1'b0, 10, "ack withheld for exception");
    exc = 8'h00;
    @(posedge clk); @(negedge clk);
    check(1'b1, 8'h1E, 1'b1, 10, "ack once interrupt wins");

    // R1: reset mid-run clears a pending take
    rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    check(1'b0, 8'h00, 1'b0, 1, "reset mid-run");
    idle_inputs();
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule